// File: doc/BRIEF.md
# Memory-Scanning Minimum, Maximum and Average Unit

This block keeps a 32-word table of unsigned data, filled by the host one word at a time through a write address, write data and write enable. When the host pulses the start input, a small controller walks the table from address 0 up to address 31, one word per clock. As it goes, a datapath keeps the smallest word seen, the largest word seen and a running total. After the last word it forms the average, which is the total divided by 32 with the fraction dropped, and raises the completion flag.

The host then picks one of the three results with a 2-bit select and reads it on the result port. The controller has three states. IDLE waits for start and is the only state that accepts writes. SCAN visits one address per cycle. FINISH latches the average and raises the flag. Its transitions are named as follows. IDLE→SCAN (start accepted). SCAN→SCAN (address below 31). SCAN→FINISH (address 31 processed). FINISH→IDLE (always). The data width is a parameter with a default of 8 bits.

Top module: `range_avg_scanner`

## Requirements
- R1: While `rst_n` is low, every table word and every result register is cleared to zero and `done` is low. After reset, all four select codes read 0.
- R2: When `wr_en` is high in IDLE, `wr_data` is stored at `wr_addr` on the rising clock edge, and a later scan uses that stored word.
- R3: A scan begins only at a rising edge where `go` is high in IDLE. Without `go`, the controller stays in IDLE and the results and `done` keep their values.
- R4: The minimum starts each run at all ones (2^W−1) and is replaced only by a strictly smaller word, so after a run it equals the smallest of the 32 words.
- R5: The maximum starts each run at 0 and is replaced only by a strictly larger word, so after a run it equals the largest of the 32 words.
- R6: The total is kept in W+5 bits, so it never overflows. The average is the total shifted right by 5 bits, with the fraction truncated. If every word is 2^W−1, the average is 2^W−1.
- R7: `done` goes high 33 rising edges after the edge that accepts `go`, which is 32 scan edges plus 1 finishing edge. It stays high until the next accepted `go`, and it is low from the edge that accepts that `go`.
- R8: The result select `sel` works as follows. 2'b00 reads 0. 2'b01 reads the minimum. 2'b10 reads the maximum. 2'b11 reads the average.
- R9: While a scan runs, `wr_en` and `go` are ignored. The table, the run's results and its `done` timing are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Table write enable |
| wr_addr | input | 5 | Table write address |
| wr_data | input | W | Table write data |
| go | input | 1 | Start a scan |
| sel | input | 2 | Result select |
| result | output | W | Selected result |
| done | output | 1 | Results ready |

## Verification
A write is due in the table at the edge where it is driven. `done` is due exactly 33 edges after the edge that accepted `go`. The result port is combinational from the result registers, so all three results can be read as soon as `done` is seen high. The bench drives inputs and samples outputs at falling edges. It counts falling edges from the one after the accepting edge, so it expects `done` on the 34th falling edge and checks that it was low on every earlier one. Expected minimum, maximum and truncated average come from a table kept in the bench. Writes driven during a run are left out of that table. The bench then confirms, with a second run, that those writes left no trace.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SCAN   = 2'd1,
        S_FINISH = 2'd2
    } scan_state_t;

    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_MIN  = 2'b01;
    localparam logic [1:0] SEL_MAX  = 2'b10;
    localparam logic [1:0] SEL_AVG  = 2'b11;
endpackage

// File: rtl/scan_table.sv
module scan_table #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [DEPTH-1:0][W-1:0] store;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  store <= '0;
        else if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];

    // R9: a gated-off write port leaves the table untouched
    assert_table_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(store));
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    output logic [AW-1:0] idx_o,
    output logic          init_o,
    output logic          step_o,
    output logic          fin_o,
    output logic          wr_ok_o,
    output logic          done_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    scan_state_t state_q, state_d;
    logic [AW-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (go_i) state_d = S_SCAN;
            S_SCAN:   if (idx_q == LAST) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: if (go_i) begin
                    idx_q  <= '0;
                    done_o <= 1'b0;
                end
                S_SCAN:   idx_q  <= idx_q + 1'b1;
                S_FINISH: done_o <= 1'b1;
                default:  idx_q  <= '0;
            endcase
        end
    end

    always_comb begin
        init_o  = (state_q == S_IDLE) && go_i;
        step_o  = (state_q == S_SCAN);
        fin_o   = (state_q == S_FINISH);
        wr_ok_o = (state_q == S_IDLE);
    end
    assign idx_o = idx_q;

    // R3: without go the controller rests in IDLE
    assert_idle_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !go_i) |=> state_q == S_IDLE);
    // R7: completion flag rises only out of FINISH
    assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state_q) == S_FINISH);
    // R7: an accepted start drops the completion flag
    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && go_i) |=> !done_o);
    // R7: scan address advances by one per cycle
    assert_scan_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SCAN && idx_q != LAST) |=> idx_q == $past(idx_q) + 1'b1);
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
    import scan_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int SHIFT = $clog2(DEPTH),
    localparam int SW    = W + SHIFT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         step_i,
    input  logic         fin_i,
    input  logic [W-1:0] word_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] result_o
);
    logic [W-1:0]  min_q, max_q, avg_q;
    logic [SW-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_q <= '0;
            max_q <= '0;
            sum_q <= '0;
            avg_q <= '0;
        end else if (init_i) begin
            min_q <= '1;
            max_q <= '0;
            sum_q <= '0;
        end else if (step_i) begin
            sum_q <= sum_q + SW'(word_i);
            if (word_i < min_q) min_q <= word_i;
            if (word_i > max_q) max_q <= word_i;
        end else if (fin_i) begin
            avg_q <= W'(sum_q >> SHIFT);
        end
    end

    always_comb begin
        unique case (sel_i)
            SEL_MIN:  result_o = min_q;
            SEL_MAX:  result_o = max_q;
            SEL_AVG:  result_o = avg_q;
            default:  result_o = '0;
        endcase
    end

    // R4: running minimum never grows during a scan
    assert_min_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> min_q <= $past(min_q));
    // R5: running maximum never shrinks during a scan
    assert_max_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> max_q >= $past(max_q));
    // R6: the total only grows while words are added
    assert_sum_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> sum_q >= $past(sum_q));
endmodule

// File: rtl/range_avg_scanner.sv
module range_avg_scanner #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          go,
    input  logic [1:0]    sel,
    output logic [W-1:0]  result,
    output logic          done
);
    logic [AW-1:0] idx;
    logic [W-1:0]  word;
    logic          init, step, fin, wr_ok;

    scan_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go_i(go), .idx_o(idx),
        .init_o(init), .step_o(step), .fin_o(fin),
        .wr_ok_o(wr_ok), .done_o(done)
    );

    scan_table #(.W(W), .DEPTH(DEPTH)) u_table (
        .clk(clk), .rst_n(rst_n), .we(wr_en && wr_ok),
        .waddr(wr_addr), .wdata(wr_data), .raddr(idx), .rdata(word)
    );

    scan_datapath #(.W(W), .DEPTH(DEPTH)) u_dp (
        .clk(clk), .rst_n(rst_n), .init_i(init), .step_i(step),
        .fin_i(fin), .word_i(word), .sel_i(sel), .result_o(result)
    );
endmodule

// File: tb/tb_range_avg_scanner.sv
module tb_range_avg_scanner;
    localparam int W = 8;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic go = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [W-1:0] result;
    logic done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int model [N];

    always #2.5 clk = ~clk;

    range_avg_scanner #(.W(W), .DEPTH(N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .go(go), .sel(sel), .result(result), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_word(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
        model[a] = d;
    endtask

    task automatic read_sel(input logic [1:0] s, output int v);
        sel = s;
        #0.5;
        v = int'(result);
    endtask

    // start a run; optionally inject a write and a second go mid-run
    task automatic run_scan(input bit disturb);
        int cnt;
        bit early;
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        cnt = 1;
        early = done;
        check("R7 done cleared after accepted go", int'(done), 0);
        while (!done && cnt < 40) begin
            if (disturb && cnt == 5) begin
                go = 1'b1; wr_en = 1'b1; wr_addr = 5'd20; wr_data = 8'd0;
            end else if (disturb && cnt == 6) begin
                go = 1'b0; wr_en = 1'b1; wr_addr = 5'd31; wr_data = 8'd255;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
            cnt++;
            if (done && cnt < 34) early = 1'b1;
        end
        wr_en = 1'b0;
        check("R7 done latency in edges", cnt - 1, 33);
        check("R7 done not early", int'(early), 0);
    endtask

    task automatic check_results(input string tag);
        int mn, mx, sm, v;
        mn = (1 << W) - 1; mx = 0; sm = 0;
        for (int i = 0; i < N; i++) begin
            sm += model[i];
            if (model[i] < mn) mn = model[i];
            if (model[i] > mx) mx = model[i];
        end
        read_sel(2'b01, v); check({"R4 min ", tag}, v, mn);
        read_sel(2'b10, v); check({"R5 max ", tag}, v, mx);
        read_sel(2'b11, v); check({"R6 avg ", tag}, v, sm / 32);
        read_sel(2'b00, v); check({"R8 sel 00 ", tag}, v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v;
        for (int i = 0; i < N; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done low in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            read_sel(2'(s), v);
            check("R1 result zero after reset", v, 0);
        end
        // R3: idle without go changes nothing
        repeat (10) @(negedge clk);
        check("R3 no run without go", int'(done), 0);

        // pattern: cleared table (R1 zero contents)
        run_scan(1'b0);
        check_results("cleared");
        // R3: results hold in idle
        repeat (8) @(negedge clk);
        check("R3 done held in idle", int'(done), 1);
        check_results("held");

        // all ones: R6 boundary
        for (int i = 0; i < N; i++) write_word(i, 255);
        run_scan(1'b0);
        check_results("all ones");

        // ramp (R2 writes used)
        for (int i = 0; i < N; i++) write_word(i, i * 7 + 3);
        run_scan(1'b0);
        check_results("ramp R2");

        // descending with duplicates
        for (int i = 0; i < N; i++) write_word(i, 200 - (i / 2) * 5);
        run_scan(1'b0);
        check_results("descending");

        // several pseudo-random fills
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < N; i++) write_word(i, int'($urandom_range(0, 255)));
            run_scan(1'b0);
            check_results("random");
        end

        // R9: writes and go during a run are ignored
        for (int i = 0; i < N; i++) write_word(i, 100 + (i % 9));
        run_scan(1'b1);
        check_results("R9 disturbed run");
        run_scan(1'b0);
        check_results("R9 table unchanged");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule